// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block collects every reset request of a small microcontroller-style system and turns them into one system reset for the rest of the chip. The eight request kinds are power-on, supply-monitor trip, external reset pin, comparator trip, missing-clock one-shot, watchdog expiry, software request and errant flash access. The supply monitor, comparator, missing-clock detector and watchdog take part only while their own enable input is high. Any request asserts the reset at once. Release comes only after every request has cleared and a programmable stretch has run out.

Level requests from outside the clock domain pass through per-source synchronizers. These assert asynchronously and release synchronously. The missing-clock detector counts cycles of a separate free-running reference clock and fires when the system clock stops toggling. For power-on and supply-monitor resets the controller pulls the bidirectional reset pin low until reset ends. A one-hot cause register records the highest-priority source of the most recent reset. On exit the controller pulses a load strobe and presents the defaults that the rest of the chip loads: boot address, clock and watchdog selection, and port latch values. Data memory is outside this block and is never cleared.

The sequencer has three states. In HOLD some request is active. In STRETCH all requests are clear and a counter runs. In RUN the system is out of reset. The transitions are: RUN to HOLD on any request; HOLD to STRETCH when no request is active; STRETCH to HOLD on any new request; STRETCH to RUN when the counter reaches its last value. Power-on forces HOLD asynchronously.

Top module: `sysrst_ctrl`

## Requirements
- R1: A one-cycle pulse on `sw_rst_req` or `flash_err` raises `sys_rst` in that same cycle, with no clock edge needed.
- R2: With its enable low, a supply-monitor trip, comparator trip, stopped system clock or watchdog expiry leaves `sys_rst` low and `cause_flags` unchanged.
- R3: `rst_pin_drive` is high only during power-on and supply-monitor resets. It stays high until the cycle in which `sys_rst` falls. It is never high during comparator, pin, watchdog, software or flash resets.
- R4: An enabled asynchronous request (comparator, supply monitor, pin, missing clock) raises `sys_rst` without any clock edge. Its release reaches the sequencer through a two-flop synchronizer.
- R5: After a single-cycle synchronous pulse, `sys_rst` stays high for exactly STRETCH_CYC+1 further cycles. After an asynchronous level request drops, it stays high for STRETCH_CYC+2 cycles, two of which come from the synchronizer.
- R6: When a reset starts, `cause_flags` latches one-hot the highest-priority active source. The bit positions are power-on 0, supply monitor 1, pin 2, missing clock 3, comparator 4, watchdog 5, software 6, flash error 7, and a lower bit wins. Outside reset the flags do not change.
- R7: Power-on sets `cause_flags` to 0x01 and clears every other flag.
- R8: `rst_exit` is high for exactly the first cycle after `sys_rst` falls. After release, `boot_addr` is 0, `clk_sel_int` is 1 (internal oscillator), `wdt_run` is 1 and `wdt_div12` is 1 (watchdog clocked from the system clock divided by 12).
- R9: During reset every bit of `port_latch` is 1 and `port_pullup_en` is 1. Both stay that way after release.
- R10: With `mcd_en` high, a system clock that stops for longer than MCD_TIMEOUT reference cycles raises `sys_rst` and records cause 0x08. A running clock never trips the detector.
- R11: An externally pulled-low reset pin causes a reset with cause 0x04. The block's own pin drive never re-triggers a reset after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ref_clk | input | 1 | Free-running reference clock for the missing-clock detector |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| vmon_trip | input | 1 | Supply monitor trip, active high |
| vmon_en | input | 1 | Enable for the supply monitor source |
| cmp_trip | input | 1 | Comparator trip, active high |
| cmp_en | input | 1 | Enable for the comparator source |
| mcd_en | input | 1 | Enable for the missing-clock source |
| wdt_expire | input | 1 | Watchdog expiry pulse, system clock domain |
| wdt_en | input | 1 | Enable for the watchdog source |
| sw_rst_req | input | 1 | Software reset pulse, system clock domain |
| flash_err | input | 1 | Errant flash access pulse, system clock domain |
| rst_pin_n | input | 1 | Sensed level of the reset pad, active low |
| rst_pin_drive | output | 1 | Pulls the reset pad low when high |
| sys_rst | output | 1 | System reset, active high |
| rst_exit | output | 1 | One-cycle strobe on the first cycle out of reset |
| cause_flags | output | 8 | One-hot cause of the last reset |
| boot_addr | output | ADDR_W | Program start address after reset |
| clk_sel_int | output | 1 | 1 selects the internal oscillator |
| wdt_run | output | 1 | Watchdog enabled after reset |
| wdt_div12 | output | 1 | Watchdog clock is system clock divided by 12 |
| port_latch | output | N_PORTS*8 | Port output latch reset values |
| port_pullup_en | output | 1 | Weak pull-up enable |

## Verification
The main function is driven from a table of synchronous pulse patterns: software alone, flash error alone, watchdog with and without its enable, and combinations of two or three at once. Single pulses confirm the exact stretch length and the source coding. Combined pulses show that the priority order picks the right winner. Pulses with the enable low show that gating removes a source instead of just lowering its rank. Directed cases then separate the asynchronous sources from the synchronous ones by the two extra synchronizer cycles. They also check that only power-on and supply-monitor resets pull the pad, and stop the system clock with the detector enabled and then disabled.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int NSRC    = 8;
    localparam int N_ASYNC = 5;

    // Source bit positions; lower index has higher priority.
    localparam int SRC_POR   = 0;
    localparam int SRC_VMON  = 1;
    localparam int SRC_PIN   = 2;
    localparam int SRC_MCD   = 3;
    localparam int SRC_CMP   = 4;
    localparam int SRC_WDT   = 5;
    localparam int SRC_SW    = 6;
    localparam int SRC_FLASH = 7;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_RUN     = 2'd2
    } rst_state_e;

    // Keep only the lowest set bit.
    function automatic logic [NSRC-1:0] pick_first(input logic [NSRC-1:0] v);
        return v & (~v + NSRC'(1));
    endfunction

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic req,
    output logic req_s
);

    logic [STAGES-1:0] q;

    // Set immediately by the request, drained one stage per clock.
    always_ff @(posedge clk or posedge req) begin
        if (req) begin
            q <= '1;
        end else begin
            q <= {q[STAGES-2:0], 1'b0};
        end
    end

    assign req_s = q[STAGES-1];

endmodule

// File: rtl/sysrst_clkmon.sv
module sysrst_clkmon #(
    parameter int DIV_LOG2 = 2,
    parameter int TIMEOUT  = 8
) (
    input  logic clk,
    input  logic ref_clk,
    input  logic rst_async,
    output logic mcd_req
);

    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT);

    logic [DIV_LOG2:0] div_q;
    logic [2:0]        beat_sh;
    logic [TW-1:0]     idle_cnt;
    logic              beat_edge;

    // Slow heartbeat from the system clock so the reference side cannot alias.
    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_ff @(posedge ref_clk or posedge rst_async) begin
        if (rst_async) begin
            beat_sh <= '0;
        end else begin
            beat_sh <= {beat_sh[1:0], div_q[DIV_LOG2]};
        end
    end

    assign beat_edge = beat_sh[2] ^ beat_sh[1];

    always_ff @(posedge ref_clk or posedge rst_async) begin
        if (rst_async) begin
            idle_cnt <= '0;
            mcd_req  <= 1'b0;
        end else if (beat_edge) begin
            idle_cnt <= '0;
            mcd_req  <= 1'b0;
        end else if (idle_cnt == T_LAST) begin
            mcd_req  <= 1'b1;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
    import sysrst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_async,
    input  logic            capture,
    input  logic [NSRC-1:0] req_vec,
    output logic [NSRC-1:0] flags
);

    always_ff @(posedge clk or posedge rst_async) begin
        if (rst_async) begin
            flags <= NSRC'(1) << SRC_POR;
        end else if (capture) begin
            flags <= pick_first(req_vec);
        end
    end

endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter int STRETCH_CYC  = 16,
    parameter int MCD_TIMEOUT  = 8,
    parameter int MCD_DIV_LOG2 = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int N_PORTS      = 4,
    parameter int ADDR_W       = 16
) (
    input  logic                 clk,
    input  logic                 ref_clk,
    input  logic                 por_n,
    input  logic                 vmon_trip,
    input  logic                 vmon_en,
    input  logic                 cmp_trip,
    input  logic                 cmp_en,
    input  logic                 mcd_en,
    input  logic                 wdt_expire,
    input  logic                 wdt_en,
    input  logic                 sw_rst_req,
    input  logic                 flash_err,
    input  logic                 rst_pin_n,
    output logic                 rst_pin_drive,
    output logic                 sys_rst,
    output logic                 rst_exit,
    output logic [NSRC-1:0]      cause_flags,
    output logic [ADDR_W-1:0]    boot_addr,
    output logic                 clk_sel_int,
    output logic                 wdt_run,
    output logic                 wdt_div12,
    output logic [N_PORTS*8-1:0] port_latch,
    output logic                 port_pullup_en
);

    localparam int CNT_W  = $clog2(STRETCH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH_CYC - 1);
    localparam int PORT_W = N_PORTS * 8;

    logic               por_req;
    logic               mcd_req;
    logic               pin_mask_q;
    logic               drive_nxt;
    logic               exit_nxt;
    logic               capture;
    logic               any_req;
    logic               in_rst;
    logic [N_ASYNC-1:0] async_raw;
    logic [N_ASYNC-1:0] async_s;
    logic [NSRC-1:0]    req_vec;
    rst_state_e         state_q, state_nxt;
    logic [CNT_W-1:0]   cnt_q, cnt_nxt;

    assign por_req = ~por_n;

    sysrst_clkmon #(
        .DIV_LOG2 (MCD_DIV_LOG2),
        .TIMEOUT  (MCD_TIMEOUT)
    ) u_clkmon (
        .clk       (clk),
        .ref_clk   (ref_clk),
        .rst_async (por_req),
        .mcd_req   (mcd_req)
    );

    // Pin request is masked while, and one cycle after, the block drives the pad.
    assign async_raw[SRC_POR]  = por_req;
    assign async_raw[SRC_VMON] = vmon_trip & vmon_en;
    assign async_raw[SRC_PIN]  = ~rst_pin_n & ~rst_pin_drive & ~pin_mask_q;
    assign async_raw[SRC_MCD]  = mcd_req & mcd_en;
    assign async_raw[SRC_CMP]  = cmp_trip & cmp_en;

    generate
        for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
            sysrst_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk   (clk),
                .req   (async_raw[g]),
                .req_s (async_s[g])
            );
        end
    endgenerate

    assign req_vec = {flash_err, sw_rst_req, wdt_expire & wdt_en, async_s};
    assign any_req = |req_vec;

    // State register.
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    // Transitions.
    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (any_req) begin
                    state_nxt = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!any_req) begin
                    state_nxt = ST_STRETCH;
                    cnt_nxt   = '0;
                end
            end
            ST_STRETCH: begin
                if (any_req) begin
                    state_nxt = ST_HOLD;
                end else if (cnt_q == CNT_LAST) begin
                    state_nxt = ST_RUN;
                end else begin
                    cnt_nxt = cnt_q + 1'b1;
                end
            end
            default: begin
                state_nxt = ST_HOLD;
                cnt_nxt   = '0;
            end
        endcase
    end

    // Outputs of the sequencer.
    always_comb begin
        in_rst    = (state_q != ST_RUN);
        sys_rst   = in_rst | any_req;
        capture   = (state_q == ST_RUN) & any_req;
        exit_nxt  = (state_q != ST_RUN) & (state_nxt == ST_RUN);
        drive_nxt = async_s[SRC_POR] | async_s[SRC_VMON]
                  | (rst_pin_drive & (state_nxt != ST_RUN));
    end

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            rst_pin_drive <= 1'b1;
            pin_mask_q    <= 1'b1;
            rst_exit      <= 1'b0;
        end else begin
            rst_pin_drive <= drive_nxt;
            pin_mask_q    <= rst_pin_drive;
            rst_exit      <= exit_nxt;
        end
    end

    // Defaults presented to the chip; reloaded throughout reset.
    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            boot_addr      <= '0;
            clk_sel_int    <= 1'b1;
            wdt_run        <= 1'b1;
            wdt_div12      <= 1'b1;
            port_latch     <= {PORT_W{1'b1}};
            port_pullup_en <= 1'b1;
        end else if (in_rst) begin
            boot_addr      <= '0;
            clk_sel_int    <= 1'b1;
            wdt_run        <= 1'b1;
            wdt_div12      <= 1'b1;
            port_latch     <= {PORT_W{1'b1}};
            port_pullup_en <= 1'b1;
        end
    end

    sysrst_cause u_cause (
        .clk       (clk),
        .rst_async (por_req),
        .capture   (capture),
        .req_vec   (req_vec),
        .flags     (cause_flags)
    );

endmodule

// File: rtl/sysrst_ctrl_chk.sv
module sysrst_ctrl_chk #(
    parameter int STRETCH_CYC = 16
) (
    input logic       clk,
    input logic       por_n,
    input logic       sw_rst_req,
    input logic       flash_err,
    input logic       sys_rst,
    input logic       rst_pin_drive,
    input logic       rst_exit,
    input logic [7:0] cause_flags
);

    logic [15:0] run_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_len <= '0;
        end else if (sys_rst) begin
            if (run_len != 16'hFFFF) begin
                run_len <= run_len + 1'b1;
            end
        end else begin
            run_len <= '0;
        end
    end

    p_sync_pulse_rst_r1: assert property (@(posedge clk) disable iff (!por_n)
        (sw_rst_req || flash_err) |-> sys_rst);

    p_drive_in_rst_r3: assert property (@(posedge clk) disable iff (!por_n)
        rst_pin_drive |-> sys_rst);

    p_min_stretch_r5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> (run_len >= 16'(STRETCH_CYC + 1)));

    p_cause_onehot_r6: assert property (@(posedge clk) disable iff (!por_n)
        $countones(cause_flags) == 1);

    p_cause_stable_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && !$past(sys_rst)) |-> $stable(cause_flags));

    p_exit_after_rst_r8: assert property (@(posedge clk) disable iff (!por_n)
        rst_exit |-> $past(sys_rst));

endmodule

bind sysrst_ctrl sysrst_ctrl_chk #(
    .STRETCH_CYC (STRETCH_CYC)
) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .sw_rst_req    (sw_rst_req),
    .flash_err     (flash_err),
    .sys_rst       (sys_rst),
    .rst_pin_drive (rst_pin_drive),
    .rst_exit      (rst_exit),
    .cause_flags   (cause_flags)
);

// File: tb/sysrst_ctrl_bench.sv
module sysrst_ctrl_bench;

    localparam int STRETCH = 16;
    localparam int NP      = 4;
    localparam int AW      = 16;

    logic osc = 1'b0;
    logic clk_run = 1'b1;
    logic clk;
    logic ref_clk = 1'b0;
    logic por_n, vmon_trip, vmon_en, cmp_trip, cmp_en, mcd_en;
    logic wdt_expire, wdt_en, sw_rst_req, flash_err, ext_pin_n;
    logic rst_pin_n, rst_pin_drive, sys_rst, rst_exit;
    logic [7:0] cause_flags;
    logic [AW-1:0] boot_addr;
    logic clk_sel_int, wdt_run, wdt_div12, port_pullup_en;
    logic [NP*8-1:0] port_latch;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 osc = ~osc;
    always #10 ref_clk = ~ref_clk;
    assign clk = osc & clk_run;
    assign rst_pin_n = ext_pin_n & ~rst_pin_drive;

    sysrst_ctrl #(.STRETCH_CYC(STRETCH), .N_PORTS(NP), .ADDR_W(AW)) u_sysrst_ctrl (
        .clk(clk), .ref_clk(ref_clk), .por_n(por_n),
        .vmon_trip(vmon_trip), .vmon_en(vmon_en),
        .cmp_trip(cmp_trip), .cmp_en(cmp_en), .mcd_en(mcd_en),
        .wdt_expire(wdt_expire), .wdt_en(wdt_en),
        .sw_rst_req(sw_rst_req), .flash_err(flash_err),
        .rst_pin_n(rst_pin_n), .rst_pin_drive(rst_pin_drive),
        .sys_rst(sys_rst), .rst_exit(rst_exit), .cause_flags(cause_flags),
        .boot_addr(boot_addr), .clk_sel_int(clk_sel_int), .wdt_run(wdt_run),
        .wdt_div12(wdt_div12), .port_latch(port_latch),
        .port_pullup_en(port_pullup_en)
    );

    // {pulse {flash,sw,wdt}, wdt_en, expect reset, expected flags}
    localparam logic [12:0] VEC [0:7] = '{
        {3'b010, 1'b1, 1'b1, 8'h40},
        {3'b100, 1'b1, 1'b1, 8'h80},
        {3'b001, 1'b1, 1'b1, 8'h20},
        {3'b001, 1'b0, 1'b0, 8'h20},
        {3'b110, 1'b1, 1'b1, 8'h40},
        {3'b011, 1'b1, 1'b1, 8'h20},
        {3'b111, 1'b0, 1'b1, 8'h40},
        {3'b000, 1'b1, 1'b0, 8'h40}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Counts negedges with sys_rst high from the current one; then checks the exit strobe.
    task automatic measure(output int hi, output int ex_ok);
        hi = 0;
        while (sys_rst && hi < 400) begin
            hi++;
            @(negedge clk);
        end
        ex_ok = int'(rst_exit);
        @(negedge clk);
        if (rst_exit) ex_ok = 0;
    endtask

    initial begin
        #1600000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, ex, w;
        por_n = 1'b0; vmon_trip = 1'b0; vmon_en = 1'b0; cmp_trip = 1'b0;
        cmp_en = 1'b0; mcd_en = 1'b0; wdt_expire = 1'b0; wdt_en = 1'b0;
        sw_rst_req = 1'b0; flash_err = 1'b0; ext_pin_n = 1'b1;
        repeat (5) @(negedge clk);

        // Reset state during power-on
        check("R7 sys_rst during power-on", int'(sys_rst), 1);
        check("R3 pin driven during power-on", int'(rst_pin_drive), 1);
        check("R9 port latches ones in reset", int'(&port_latch), 1);
        check("R9 pull-ups in reset", int'(port_pullup_en), 1);

        por_n = 1'b1;
        @(negedge clk);
        measure(hi, ex);
        check("R5 power-on release length", hi, STRETCH + 2);
        check("R8 exit strobe after power-on", ex, 1);
        check("R7 cause after power-on", int'(cause_flags), 8'h01);
        check("R3 pin released after reset", int'(rst_pin_drive), 0);
        check("R8 boot address", int'(boot_addr), 0);
        check("R8 internal oscillator", int'(clk_sel_int), 1);
        check("R8 watchdog on", int'(wdt_run), 1);
        check("R8 watchdog div12", int'(wdt_div12), 1);
        check("R9 port latches after release", int'(&port_latch), 1);
        check("R9 pull-ups after release", int'(port_pullup_en), 1);
        repeat (5) @(negedge clk);
        check("R11 no self-trigger after power-on", int'(sys_rst), 0);

        // Table of synchronous pulse patterns
        for (int i = 0; i < 8; i++) begin
            logic [12:0] v;
            v = VEC[i];
            {flash_err, sw_rst_req, wdt_expire} = v[12:10];
            wdt_en = v[9];
            #1;
            if (v[12] || v[11]) check($sformatf("R1 same-cycle reset vec %0d", i), int'(sys_rst), 1);
            @(negedge clk);
            {flash_err, sw_rst_req, wdt_expire} = 3'b000;
            measure(hi, ex);
            check($sformatf("R5 R2 stretch length vec %0d", i), hi, v[8] ? STRETCH + 1 : 0);
            check($sformatf("R6 R2 cause vec %0d", i), int'(cause_flags), int'(v[7:0]));
            if (v[8]) check($sformatf("R8 exit strobe vec %0d", i), ex, 1);
        end

        // Comparator gated off
        cmp_en = 1'b0; cmp_trip = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 comparator gated", int'(sys_rst), 0);
        cmp_trip = 1'b0;
        @(negedge clk);

        // Comparator enabled: asynchronous assertion, no pin drive
        cmp_en = 1'b1; cmp_trip = 1'b1;
        #1;
        check("R4 async assertion without edge", int'(sys_rst), 1);
        repeat (3) @(negedge clk);
        check("R3 no pin drive for comparator", int'(rst_pin_drive), 0);
        cmp_trip = 1'b0;
        @(negedge clk);
        measure(hi, ex);
        check("R4 R5 comparator release length", hi, STRETCH + 2);
        check("R6 comparator cause", int'(cause_flags), 8'h10);

        // Comparator and software together: comparator wins
        cmp_trip = 1'b1; sw_rst_req = 1'b1;
        @(negedge clk);
        cmp_trip = 1'b0; sw_rst_req = 1'b0;
        @(negedge clk);
        measure(hi, ex);
        check("R6 comparator beats software", int'(cause_flags), 8'h10);

        // Supply monitor gated off
        vmon_en = 1'b0; vmon_trip = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 supply monitor gated", int'(sys_rst), 0);
        vmon_trip = 1'b0;
        @(negedge clk);

        // Supply monitor enabled: pad driven low
        vmon_en = 1'b1; vmon_trip = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 pin driven for supply monitor", int'(rst_pin_drive), 1);
        check("R3 pad low for supply monitor", int'(rst_pin_n), 0);
        vmon_trip = 1'b0;
        @(negedge clk);
        measure(hi, ex);
        check("R5 supply monitor release length", hi, STRETCH + 2);
        check("R6 supply monitor cause", int'(cause_flags), 8'h02);
        check("R3 pin released after supply reset", int'(rst_pin_drive), 0);
        repeat (4) @(negedge clk);
        check("R11 no self-trigger after supply reset", int'(sys_rst), 0);

        // External pin pulled low
        ext_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 external pin resets", int'(sys_rst), 1);
        check("R3 no drive for external pin", int'(rst_pin_drive), 0);
        ext_pin_n = 1'b1;
        @(negedge clk);
        measure(hi, ex);
        check("R11 external pin release length", hi, STRETCH + 2);
        check("R11 external pin cause", int'(cause_flags), 8'h04);

        // Missing clock with detector disabled
        mcd_en = 1'b0;
        @(negedge clk);
        clk_run = 1'b0;
        #600;
        check("R10 R2 stopped clock ignored when disabled", int'(sys_rst), 0);
        @(negedge osc);
        clk_run = 1'b1;
        repeat (60) @(negedge clk);
        check("R2 cause unchanged after gated stop", int'(cause_flags), 8'h04);

        // Missing clock with detector enabled
        mcd_en = 1'b1;
        repeat (40) @(negedge clk);
        check("R10 running clock does not trip", int'(sys_rst), 0);
        clk_run = 1'b0;
        #600;
        check("R10 stopped clock raises reset", int'(sys_rst), 1);
        @(negedge osc);
        clk_run = 1'b1;
        w = 0;
        @(negedge clk);
        while (sys_rst && w < 300) begin
            w++;
            @(negedge clk);
        end
        check("R10 reset released after clock returns", int'(sys_rst), 0);
        check("R10 missing clock cause", int'(cause_flags), 8'h08);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule